// File: doc/BRIEF.md
# Segment Index Tree Walker

This block turns a virtual address into a segment record when the segment translation cache misses. Software lays out a sorted multi-way search tree in memory whose keys are segment start addresses and whose leaf values are slots in a segment table. The walker starts at the root pointer and reads one node per level. At each inner node it picks the branch whose key interval holds the address. At the leaf it takes the value stored beside the largest key not above the address. It then reads that slot of the segment table and confirms that the segment really spans the address.

Nodes are first looked up in a small direct-mapped node store. Only a miss there issues a read on the memory request port, which has a valid/ready request and a response of any latency. The segment table sits behind a read port with a fixed one-cycle latency. Only one walk is in flight at a time. The result is a one-cycle response that carries either the segment record or a fault code.

Top module: `seg_index_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid`, `mem_req_valid` and `seg_rd_en` are 0.
- R2: A node is one memory word. Bits [2:0] hold the key count (0..7) and bit 3 is the leaf flag. Key k (32 bits) sits at bit 4+32k, and child k (32 bits) sits at bit 228+32k. At an inner node the walker follows child n, where n is the number of valid keys that are less than or equal to the address (unsigned), so an address equal to a key goes right of it.
- R3: At a leaf with n ≥ 1 such keys, child n-1 is the segment slot. The walker reads that slot and returns fault 0 with `rsp_idx`, base (record bits [31:0]), limit (bits [63:32]) and offset (bits [95:64]). On any fault the index, base, limit and offset outputs read 0.
- R4: An address below every valid key of the leaf it reaches gives fault 3.
- R5: An address below the segment base or above its inclusive limit gives fault 4.
- R6: A node whose key count is 0 gives fault 1.
- R7: The root is level 1. An inner node met at level 8 gives fault 2. A leaf at level 8 still completes.
- R8: `req_ready` is low from the cycle after a request is accepted until `rsp_valid` has been high for exactly one cycle. It is high again in the cycle after.
- R9: Nodes are held in a 4-set direct-mapped store indexed by pointer bits [7:6] and tagged with the full pointer. A held node is not read from memory again. Reset empties the store.
- R10: A memory request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready` is seen. Responses of any latency are accepted.
- R11: A leaf value of 2048 or more (beyond the segment table) gives fault 5 and does not read the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request from the segment cache miss path |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to resolve |
| root_ptr | input | 32 | Memory pointer of the tree root node |
| mem_req_valid | output | 1 | Node read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Pointer of the node to read |
| mem_rsp_valid | input | 1 | Node data returned |
| mem_rsp_data | input | 484 | Node contents |
| seg_rd_en | output | 1 | Segment table read strobe |
| seg_rd_idx | output | 11 | Segment table slot |
| seg_rd_data | input | 96 | Segment record, one cycle after the strobe |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 3 | 0 ok, 1 empty node, 2 too deep, 3 no key, 4 out of range, 5 bad slot |
| rsp_idx | output | 11 | Segment slot found |
| rsp_base | output | 32 | Segment base |
| rsp_limit | output | 32 | Segment inclusive limit |
| rsp_offset | output | 32 | Segment offset |

## Verification
The bench goes after addresses equal to a separator key and one below it. A walker that compares with the wrong strictness there lands in the neighbouring leaf and returns the wrong segment or a spurious range fault. It builds chains that put a leaf exactly at level 8 and at level 9, plus a node that points to itself, so an off-by-one depth counter either faults a legal tree or never stops. It counts memory reads across a sequence of walks whose nodes collide in the node store, which exposes a store that never hits, never evicts, or survives reset. It also checks a full seven-key leaf, an empty node, an out-of-table slot and the gaps between segments.

// File: rtl/segwalk_pkg.sv
package segwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT,
    ST_EVAL,
    ST_SRD,
    ST_SCHK,
    ST_RESP
  } walk_state_t;

  localparam logic [2:0] FLT_NONE   = 3'd0;
  localparam logic [2:0] FLT_EMPTY  = 3'd1;
  localparam logic [2:0] FLT_DEPTH  = 3'd2;
  localparam logic [2:0] FLT_NOKEY  = 3'd3;
  localparam logic [2:0] FLT_RANGE  = 3'd4;
  localparam logic [2:0] FLT_BADIDX = 3'd5;

endpackage

// File: rtl/segwalk_rst_sync.sv
module segwalk_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end

endmodule

// File: rtl/segwalk_node_cache.sv
module segwalk_node_cache #(
  parameter int PTR_W  = 32,
  parameter int NODE_W = 484,
  parameter int SETS   = 4,
  parameter int ALIGN  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  lk_ptr,
  output logic              lk_hit,
  output logic [NODE_W-1:0] lk_node,
  input  logic              fill_en,
  input  logic [PTR_W-1:0]  fill_ptr,
  input  logic [NODE_W-1:0] fill_node
);

  localparam int SET_W = $clog2(SETS);

  logic [SET_W-1:0]  lk_set;
  logic [SET_W-1:0]  fill_set;
  logic [SETS-1:0]   vld;
  logic [PTR_W-1:0]  tag [SETS];
  logic [NODE_W-1:0] dat [SETS];

  assign lk_set   = lk_ptr[ALIGN +: SET_W];
  assign fill_set = fill_ptr[ALIGN +: SET_W];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic              wr_en;
    logic              v_q;
    logic [PTR_W-1:0]  t_q;
    logic [NODE_W-1:0] d_q;

    assign wr_en = fill_en && (fill_set == SET_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (wr_en) begin
        v_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        t_q <= fill_ptr;
        d_q <= fill_node;
      end
    end

    assign vld[s] = v_q;
    assign tag[s] = t_q;
    assign dat[s] = d_q;
  end

  assign lk_hit  = vld[lk_set] && (tag[lk_set] == lk_ptr);
  assign lk_node = dat[lk_set];

  // R9: a node just written is found again under its own pointer
  a_r9_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (vld[$past(fill_set)] && (tag[$past(fill_set)] == $past(fill_ptr))));

endmodule

// File: rtl/segwalk_key_select.sv
module segwalk_key_select #(
  parameter int VA_W     = 32,
  parameter int PTR_W    = 32,
  parameter int MAX_KEYS = 7
) (
  input  logic [$clog2(MAX_KEYS+1)+MAX_KEYS*VA_W+(MAX_KEYS+1)*PTR_W:0] node,
  input  logic [VA_W-1:0]  va,
  output logic [$clog2(MAX_KEYS+1)-1:0] cnt,
  output logic             leaf,
  output logic [$clog2(MAX_KEYS+1)-1:0] n_le,
  output logic [PTR_W-1:0] down_ptr,
  output logic [PTR_W-1:0] leaf_val
);

  localparam int CNT_W   = $clog2(MAX_KEYS+1);
  localparam int FANOUT  = MAX_KEYS + 1;
  localparam int KEY_LO  = CNT_W + 1;
  localparam int KID_LO  = KEY_LO + MAX_KEYS*VA_W;

  logic [MAX_KEYS-1:0] le;
  logic [PTR_W-1:0]    kid [FANOUT];

  assign cnt  = node[CNT_W-1:0];
  assign leaf = node[CNT_W];

  for (genvar k = 0; k < MAX_KEYS; k++) begin : g_key
    logic [VA_W-1:0] key;
    assign key   = node[KEY_LO + k*VA_W +: VA_W];
    assign le[k] = (CNT_W'(k) < cnt) && (key <= va);
  end

  for (genvar c = 0; c < FANOUT; c++) begin : g_kid
    assign kid[c] = node[KID_LO + c*PTR_W +: PTR_W];
  end

  always_comb begin
    n_le = '0;
    for (int i = 0; i < MAX_KEYS; i++) begin
      n_le = n_le + CNT_W'(le[i]);
    end
  end

  assign down_ptr = kid[n_le];
  assign leaf_val = kid[n_le - 1'b1];

endmodule

// File: rtl/seg_index_walker.sv
module seg_index_walker #(
  parameter int VA_W      = 32,
  parameter int PTR_W     = 32,
  parameter int IDX_W     = 11,
  parameter int MAX_KEYS  = 7,
  parameter int MAX_DEPTH = 8,
  parameter int NC_SETS   = 4,
  parameter int NODE_ALIGN = 6,
  localparam int CNT_W    = $clog2(MAX_KEYS+1),
  localparam int NODE_W   = CNT_W + 1 + MAX_KEYS*VA_W + (MAX_KEYS+1)*PTR_W,
  localparam int SEG_W    = 3*VA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PTR_W-1:0]  root_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PTR_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [NODE_W-1:0] mem_rsp_data,
  output logic              seg_rd_en,
  output logic [IDX_W-1:0]  seg_rd_idx,
  input  logic [SEG_W-1:0]  seg_rd_data,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [VA_W-1:0]   rsp_base,
  output logic [VA_W-1:0]   rsp_limit,
  output logic [VA_W-1:0]   rsp_offset
);

  import segwalk_pkg::*;

  localparam int DEPTH_W = $clog2(MAX_DEPTH+1);

  logic rst_n_i;

  segwalk_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  walk_state_t state_q, state_d;

  logic [VA_W-1:0]    va_q,    va_d;
  logic [PTR_W-1:0]   ptr_q,   ptr_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [NODE_W-1:0]  node_q,  node_d;
  logic [IDX_W-1:0]   slot_q,  slot_d;
  logic [2:0]         fault_q, fault_d;
  logic [IDX_W-1:0]   ridx_q,  ridx_d;
  logic [VA_W-1:0]    base_q,  base_d;
  logic [VA_W-1:0]    lim_q,   lim_d;
  logic [VA_W-1:0]    off_q,   off_d;

  logic               accept;
  logic               dp_en;

  logic               nc_hit;
  logic [NODE_W-1:0]  nc_node;
  logic               fill_en;

  logic [CNT_W-1:0]   ks_cnt;
  logic               ks_leaf;
  logic [CNT_W-1:0]   ks_nle;
  logic [PTR_W-1:0]   ks_down;
  logic [PTR_W-1:0]   ks_leafval;

  logic [VA_W-1:0]    rec_base;
  logic [VA_W-1:0]    rec_lim;
  logic [VA_W-1:0]    rec_off;

  segwalk_node_cache #(
    .PTR_W  (PTR_W),
    .NODE_W (NODE_W),
    .SETS   (NC_SETS),
    .ALIGN  (NODE_ALIGN)
  ) u_node_cache (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .lk_ptr    (ptr_q),
    .lk_hit    (nc_hit),
    .lk_node   (nc_node),
    .fill_en   (fill_en),
    .fill_ptr  (ptr_q),
    .fill_node (mem_rsp_data)
  );

  segwalk_key_select #(
    .VA_W     (VA_W),
    .PTR_W    (PTR_W),
    .MAX_KEYS (MAX_KEYS)
  ) u_key_select (
    .node     (node_q),
    .va       (va_q),
    .cnt      (ks_cnt),
    .leaf     (ks_leaf),
    .n_le     (ks_nle),
    .down_ptr (ks_down),
    .leaf_val (ks_leafval)
  );

  assign rec_base = seg_rd_data[0      +: VA_W];
  assign rec_lim  = seg_rd_data[VA_W   +: VA_W];
  assign rec_off  = seg_rd_data[2*VA_W +: VA_W];

  assign accept = req_valid && (state_q == ST_IDLE);
  assign dp_en  = accept || (state_q != ST_IDLE);

  // next-state and datapath decisions
  always_comb begin
    state_d = state_q;
    va_d    = va_q;
    ptr_d   = ptr_q;
    depth_d = depth_q;
    node_d  = node_q;
    slot_d  = slot_q;
    fault_d = fault_q;
    ridx_d  = ridx_q;
    base_d  = base_q;
    lim_d   = lim_q;
    off_d   = off_q;

    req_ready     = 1'b0;
    mem_req_valid = 1'b0;
    seg_rd_en     = 1'b0;
    fill_en       = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          va_d    = req_va;
          ptr_d   = root_ptr;
          depth_d = DEPTH_W'(1);
          fault_d = FLT_NONE;
          ridx_d  = '0;
          base_d  = '0;
          lim_d   = '0;
          off_d   = '0;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (nc_hit) begin
          node_d  = nc_node;
          state_d = ST_EVAL;
        end else begin
          state_d = ST_MREQ;
        end
      end
      ST_MREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (mem_rsp_valid) begin
          node_d  = mem_rsp_data;
          fill_en = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (ks_cnt == '0) begin
          fault_d = FLT_EMPTY;
          state_d = ST_RESP;
        end else if (ks_leaf) begin
          if (ks_nle == '0) begin
            fault_d = FLT_NOKEY;
            state_d = ST_RESP;
          end else if (ks_leafval[PTR_W-1:IDX_W] != '0) begin
            fault_d = FLT_BADIDX;
            state_d = ST_RESP;
          end else begin
            slot_d  = ks_leafval[IDX_W-1:0];
            state_d = ST_SRD;
          end
        end else if (depth_q == DEPTH_W'(MAX_DEPTH)) begin
          fault_d = FLT_DEPTH;
          state_d = ST_RESP;
        end else begin
          ptr_d   = ks_down;
          depth_d = depth_q + 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_SRD: begin
        seg_rd_en = 1'b1;
        state_d   = ST_SCHK;
      end
      ST_SCHK: begin
        if ((va_q < rec_base) || (va_q > rec_lim)) begin
          fault_d = FLT_RANGE;
        end else begin
          ridx_d = slot_q;
          base_d = rec_base;
          lim_d  = rec_lim;
          off_d  = rec_off;
        end
        state_d = ST_RESP;
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // datapath registers, enabled while a walk is live
  always_ff @(posedge clk) begin
    if (dp_en) begin
      va_q    <= va_d;
      ptr_q   <= ptr_d;
      depth_q <= depth_d;
      node_q  <= node_d;
      slot_q  <= slot_d;
      fault_q <= fault_d;
      ridx_q  <= ridx_d;
      base_q  <= base_d;
      lim_q   <= lim_d;
      off_q   <= off_d;
    end
  end

  assign mem_req_addr = ptr_q;
  assign seg_rd_idx   = slot_q;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_fault    = fault_q;
  assign rsp_idx      = ridx_q;
  assign rsp_base     = base_q;
  assign rsp_limit    = lim_q;
  assign rsp_offset   = off_q;

  // R8: busy while a result is presented, and the result lasts one cycle
  a_r8_busy_at_rsp: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> !req_ready);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R10: an unanswered request is held with the same pointer
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7: the level counter stays inside the permitted range during a walk
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q != ST_IDLE) |-> ((depth_q >= DEPTH_W'(1)) && (depth_q <= DEPTH_W'(MAX_DEPTH))));

  // R3: a faulted result carries no record
  a_r3_fault_clears: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_valid && (rsp_fault != FLT_NONE)) |->
      ((rsp_idx == '0) && (rsp_base == '0) && (rsp_limit == '0) && (rsp_offset == '0)));

  // R3: a table read is a single strobe, followed by a result
  a_r3_read_once: assert property (@(posedge clk) disable iff (!rst_n_i)
    seg_rd_en |=> (!seg_rd_en ##1 rsp_valid));

  // R11: no table read follows an out-of-table slot
  a_r11_no_read_on_bad: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_valid && (rsp_fault == FLT_BADIDX)) |-> !$past(seg_rd_en, 2));

endmodule

// File: tb/seg_index_walker_bench.sv
module seg_index_walker_bench;

  localparam int NODE_W = 484;
  localparam int NSEG   = 20;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_va;
  logic [31:0]  root_ptr;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid;
  logic [NODE_W-1:0] mem_rsp_data;
  logic         seg_rd_en;
  logic [10:0]  seg_rd_idx;
  logic [95:0]  seg_rd_data;
  logic         rsp_valid;
  logic [2:0]   rsp_fault;
  logic [10:0]  rsp_idx;
  logic [31:0]  rsp_base;
  logic [31:0]  rsp_limit;
  logic [31:0]  rsp_offset;

  seg_index_walker u_seg_index_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .root_ptr(root_ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .seg_rd_en(seg_rd_en), .seg_rd_idx(seg_rd_idx), .seg_rd_data(seg_rd_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_idx(rsp_idx),
    .rsp_base(rsp_base), .rsp_limit(rsp_limit), .rsp_offset(rsp_offset)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  int mem_reads = 0;

  logic [NODE_W-1:0] nodes [32];
  logic [95:0]       seg_tab [2048];

  // memory model: random ready, latency 1..4
  logic        pend;
  int          lat;
  logic [31:0] pend_addr;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= (($urandom % 4) != 0);
    if (mem_req_valid && mem_req_ready) begin
      mem_reads <= mem_reads + 1;
      pend      <= 1'b1;
      lat       <= 1 + ($urandom % 4);
      pend_addr <= mem_req_addr;
    end else if (pend) begin
      if (lat <= 1) begin
        pend          <= 1'b0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= nodes[pend_addr[10:6]];
      end else begin
        lat <= lat - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (seg_rd_en) seg_rd_data <= seg_tab[seg_rd_idx];
  end

  function automatic logic [31:0] s_base(int i);
    return 32'((i + 1) << 16);
  endfunction
  function automatic logic [31:0] s_lim(int i);
    return s_base(i) + 32'h8000 + 32'(i % 3) * 32'h3000 - 32'd1;
  endfunction
  function automatic logic [31:0] s_off(int i);
    return 32'h4000_0000 + 32'(i) * 32'h0012_3000;
  endfunction
  function automatic logic [10:0] s_idx(int i);
    return 11'((i * 613 + 7) % 2048);
  endfunction

  task automatic set_hdr(int n, int cnt, bit leaf);
    nodes[n][2:0] = 3'(cnt);
    nodes[n][3]   = leaf;
  endtask
  task automatic set_key(int n, int k, logic [31:0] v);
    nodes[n][4 + 32*k +: 32] = v;
  endtask
  task automatic set_kid(int n, int k, logic [31:0] v);
    nodes[n][228 + 32*k +: 32] = v;
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference from the flat segment list, not from the tree
  task automatic ref_lookup(input logic [31:0] va, output logic [2:0] f,
                            output logic [10:0] ix, output logic [31:0] b, l, o);
    int best;
    best = -1;
    for (int i = 0; i < NSEG; i++) if (s_base(i) <= va) best = i;
    f = 3'd0; ix = '0; b = '0; l = '0; o = '0;
    if (best < 0) f = 3'd3;
    else if (va > s_lim(best)) f = 3'd4;
    else begin
      ix = s_idx(best); b = s_base(best); l = s_lim(best); o = s_off(best);
    end
  endtask

  logic [2:0]  g_f;
  logic [10:0] g_ix;
  logic [31:0] g_b, g_l, g_o;
  int          g_reads;

  task automatic walk(input logic [31:0] va, input string tag);
    int  n;
    int  r0;
    bit  busy_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = mem_reads;
    req_valid = 1'b1;
    req_va    = va;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    n = 0;
    while (!rsp_valid && n < 2000) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) begin
      vectors++; misses++;
      $display("FAIL R8 %s: actual no result expected result", tag);
    end
    g_f = rsp_fault; g_ix = rsp_idx; g_b = rsp_base; g_l = rsp_limit; g_o = rsp_offset;
    g_reads = mem_reads - r0;
    check({"R8 busy ", tag}, 64'(busy_ok), 64'd1);
    @(negedge clk);
    check({"R8 pulse ", tag}, {62'd0, rsp_valid, req_ready}, 64'b01);
  endtask

  task automatic walk_ref(input logic [31:0] va, input string tag);
    logic [2:0] ef; logic [10:0] ei; logic [31:0] eb, el, eo;
    walk(va, tag);
    ref_lookup(va, ef, ei, eb, el, eo);
    check({tag, " fault"},  64'(g_f),  64'(ef));
    check({tag, " idx"},    64'(g_ix), 64'(ei));
    check({tag, " base"},   64'(g_b),  64'(eb));
    check({tag, " limit"},  64'(g_l),  64'(el));
    check({tag, " offset"}, 64'(g_o),  64'(eo));
  endtask

  task automatic walk_fault(input logic [31:0] va, input logic [2:0] ef, input string tag);
    walk(va, tag);
    check({tag, " fault"}, 64'(g_f), 64'(ef));
    check({tag, " zero record"}, {g_ix, g_b, g_l[20:0]}, 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] va;
    void'($urandom(32'd2718));
    req_valid = 1'b0; req_va = '0; root_ptr = 32'h40;
    pend = 1'b0; lat = 0; pend_addr = '0;
    mem_rsp_data = '0; seg_rd_data = '0;
    for (int i = 0; i < 32; i++) nodes[i] = '0;
    for (int i = 0; i < 2048; i++) seg_tab[i] = '0;
    for (int i = 0; i < NSEG; i++) seg_tab[s_idx(i)] = {s_off(i), s_lim(i), s_base(i)};

    // main tree: root node 1, leaves nodes 2..5
    set_hdr(1, 3, 1'b0);
    for (int k = 0; k < 3; k++) set_key(1, k, s_base(5 * (k + 1)));
    for (int k = 0; k < 4; k++) set_kid(1, k, 32'((k + 2) << 6));
    for (int lf = 0; lf < 4; lf++) begin
      set_hdr(lf + 2, 5, 1'b1);
      for (int j = 0; j < 5; j++) begin
        set_key(lf + 2, j, s_base(5 * lf + j));
        set_kid(lf + 2, j, 32'(s_idx(5 * lf + j)));
      end
    end
    set_hdr(6, 0, 1'b0);
    set_hdr(7, 1, 1'b0); set_key(7, 0, 0); set_kid(7, 0, 32'(7 << 6)); set_kid(7, 1, 32'(7 << 6));
    for (int n = 8; n < 15; n++) begin
      set_hdr(n, 1, 1'b0); set_key(n, 0, 0);
      set_kid(n, 0, 32'((n + 1) << 6)); set_kid(n, 1, 32'((n + 1) << 6));
    end
    set_hdr(15, 1, 1'b1); set_key(15, 0, s_base(0)); set_kid(15, 0, 32'(s_idx(0)));
    set_hdr(16, 1, 1'b0); set_key(16, 0, 0); set_kid(16, 0, 32'(8 << 6)); set_kid(16, 1, 32'(8 << 6));
    set_hdr(17, 1, 1'b1); set_key(17, 0, 0); set_kid(17, 0, 32'h900);
    set_hdr(18, 7, 1'b1);
    for (int j = 0; j < 7; j++) begin
      set_key(18, j, s_base(j)); set_kid(18, j, 32'(s_idx(j)));
    end

    do_reset();
    check("R1 reset outputs", {60'd0, req_ready, rsp_valid, mem_req_valid, seg_rd_en}, 64'b1000);

    // R9 node store hits, conflict eviction in set 1
    root_ptr = 32'h40;
    walk_ref(s_base(1) + 32'h10, "R9 cold");
    check("R9 cold reads", 64'(g_reads), 64'd2);
    walk_ref(s_base(1) + 32'h20, "R9 warm");
    check("R9 warm reads", 64'(g_reads), 64'd0);
    walk_ref(s_base(17) + 32'h30, "R9 evict");
    check("R9 evict reads", 64'(g_reads), 64'd1);
    walk_ref(s_base(2) + 32'h40, "R9 refetch");
    check("R9 refetch reads", 64'(g_reads), 64'd1);

    // R2 separator boundaries
    walk_ref(s_base(5), "R2 equal key");
    check("R2 equal key idx", 64'(g_ix), 64'(s_idx(5)));
    walk_ref(s_base(5) - 32'd1, "R2 below key");
    check("R2 below key fault", 64'(g_f), 64'd4);
    walk_ref(s_base(15), "R2 last separator");
    walk_ref(s_base(19), "R3 last segment");
    // R4 and R5 edges
    walk_fault(32'h0000_FFFF, 3'd3, "R4 below all keys");
    walk_ref(s_lim(7), "R5 limit inclusive");
    walk_fault(s_lim(7) + 32'd1, 3'd4, "R5 past limit");
    walk_fault(s_lim(19) + 32'd1, 3'd4, "R5 past top");
    // R6 empty node
    root_ptr = 32'(6 << 6);
    walk_fault(s_base(3), 3'd1, "R6 empty");
    // R7 depth
    root_ptr = 32'(7 << 6);
    walk_fault(s_base(3), 3'd2, "R7 self loop");
    check("R7 self loop reads", 64'(g_reads), 64'd1);
    root_ptr = 32'(8 << 6);
    walk_ref(s_base(0) + 32'd4, "R7 leaf at level 8");
    root_ptr = 32'(16 << 6);
    walk_fault(s_base(0) + 32'd4, 3'd2, "R7 leaf at level 9");
    // R11 slot beyond table
    root_ptr = 32'(17 << 6);
    walk_fault(s_base(0), 3'd5, "R11 bad slot");
    // R3 full seven-key leaf
    root_ptr = 32'(18 << 6);
    walk_ref(s_base(6) + 32'h10, "R3 full leaf top");
    walk_ref(s_base(0), "R3 full leaf first");

    // random walks on the main tree (R2 R3 R4 R5 R10)
    root_ptr = 32'h40;
    for (int t = 0; t < 150; t++) begin
      va = 32'($urandom % 32'h15_0000);
      walk_ref(va, "R2 R3 R10 random");
    end

    // R9 reset empties the store
    do_reset();
    walk_ref(s_base(1) + 32'h10, "R9 after reset");
    check("R9 after reset reads", 64'(g_reads), 64'd2);

    summary();
    $finish;
  end

endmodule